// File: doc/BRIEF.md
# Half-Band Twice-Rate Interpolating FIR Filter

This block raises the sample rate of a signed data stream by two. Every input sample it accepts produces two output words. The first word (phase 0) comes from eleven pre-added symmetric tap pairs. The second word (phase 1) is a single delayed sample scaled by the centre coefficient. The 43-tap linear-phase response is fixed, and every other tap of it is zero. Because of this, only eleven coefficient multipliers and one centre multiplier are built. Both output words of a sample are computed in parallel from one snapshot of a 22-deep sample line and then handed out one after the other.

Both sides are valid/ready streams:

- **Input side.** A sample moves on a clock edge where `in_valid` and `in_ready` are both high.
- **Output side.** A word moves on an edge where `out_valid` and `out_ready` are both high.
- **Stall.** While `out_ready` is low, the presented word does not change. No new sample can be taken once a sample is already waiting in the line.
- **Throughput.** With the output never stalled, the block takes one sample every two cycles and keeps `out_valid` high continuously.

The parameter `EXTRA_STAGE` inserts one register slice in front of the sample line. This lets a second channel be delayed by exactly one clock relative to the first.

Top module: `hbf_interp2`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the block shows `out_valid` = 0 with `out_data` = 0. `in_ready` is 1 while nothing is stored, and the sample history reads as all zeros.
- R2: Each accepted sample yields exactly two output transfers, in order. The first has `out_phase` = 0 (outer-pair sum). The second has `out_phase` = 1 (centre product). After a phase-0 transfer, phase 1 is presented on the very next cycle.
- R3: The output stream equals the twice-rate convolution with the 43 coefficients 1, 0, -3, 0, 8, 0, -16, 0, 29, 0, -50, 0, 81, 0, -131, 0, 216, 0, -400, 0, 1264, 1998, 1264, and then the same values mirrored back to 1. A single input of 2048 between zeros therefore reproduces this list word for word, with its peak of 1998 at output index 21.
- R4: The phase-1 word for input sample n is the scaled value of 1998 × x[n-10].
- R5: Each full-precision sum is scaled as (sum + 2^(SHIFT-1)) arithmetically shifted right by SHIFT, which is round half up. SHIFT defaults to 11.
- R6: Scaled values above 2^(OW-1)-1 output 2^(OW-1)-1 (32767 by default). Values below -2^(OW-1) output -2^(OW-1) (-32768 by default).
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_phase` are held. A sample that is already waiting blocks `in_ready`.
- R8: With `EXTRA_STAGE` = 0 and the output idle, a sample accepted at edge k puts its phase-0 word on the output from edge k+1. With `EXTRA_STAGE` = 1, this happens from edge k+2.
- R9: A reset applied mid-stream discards all held samples and pending words. An impulse sent afterwards reproduces the coefficient list of R3 with no residue.
- R10: With `out_ready` held at 1 and input always offered, `out_valid` stays at 1 on every cycle, with no bubble between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output word presented |
| out_ready | input | 1 | Downstream takes the word this cycle |
| out_data | output | OW | Signed filtered word |
| out_phase | output | 1 | 0 = outer-pair sum, 1 = centre product |

## Verification
The tightest cycle is the one where the phase-1 word leaves while a new sample shifts into the line. In that same cycle, the two new results are loaded into the output registers from the old line contents. This is provoked by streaming samples back to back with `out_ready` held high, and again with `out_ready` toggled at random. A behavioural convolution model in the bench keeps its own sample history and predicts every word and phase. The stream is judged by comparing each transfer against that model and by requiring `out_valid` to stay high through the back-to-back run. Stalls during random back-pressure are also checked, by confirming that the presented word stays unchanged.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  localparam int HB_PAIRS  = 11;
  localparam int HB_CENTRE = 1998;
  localparam int HB_COEF_W = 12;

  function automatic int hb_outer_coef(input int idx);
    case (idx)
      0:       return 1;
      1:       return -3;
      2:       return 8;
      3:       return -16;
      4:       return 29;
      5:       return -50;
      6:       return 81;
      7:       return -131;
      8:       return 216;
      9:       return -400;
      10:      return 1264;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/hbf_tap_line.sv
module hbf_tap_line #(
  parameter int DW  = 16,
  parameter int LEN = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift,
  input  logic                 consume,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] taps [LEN],
  output logic                 fresh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LEN; i++) taps[i] <= '0;
      fresh <= 1'b0;
    end else begin
      if (shift) begin
        taps[0] <= din;
        for (int i = 1; i < LEN; i++) taps[i] <= taps[i-1];
      end
      if (shift) fresh <= 1'b1;
      else if (consume) fresh <= 1'b0;
    end
  end
endmodule

// File: rtl/hbf_round_sat.sv
module hbf_round_sat #(
  parameter int IW    = 34,
  parameter int OW    = 16,
  parameter int SHIFT = 11
) (
  input  logic signed [IW-1:0] acc,
  output logic signed [OW-1:0] y
);
  localparam logic signed [IW-1:0] HALF = IW'(longint'(1) <<< (SHIFT-1));
  localparam logic signed [IW-1:0] HI   = IW'((longint'(1) <<< (OW-1)) - 1);
  localparam logic signed [IW-1:0] LO   = IW'(-(longint'(1) <<< (OW-1)));

  logic signed [IW-1:0] sh;
  assign sh = (acc + HALF) >>> SHIFT;

  always_comb begin
    if (sh > HI)      y = HI[OW-1:0];
    else if (sh < LO) y = LO[OW-1:0];
    else              y = sh[OW-1:0];
  end
endmodule

// File: rtl/hbf_phase_mac.sv
module hbf_phase_mac import hbf_pkg::*; #(
  parameter int DW    = 16,
  parameter int OW    = 16,
  parameter int SHIFT = 11
) (
  input  logic signed [DW-1:0] taps [2*HB_PAIRS],
  output logic signed [OW-1:0] outer_y,
  output logic signed [OW-1:0] centre_y
);
  localparam int NT   = 2 * HB_PAIRS;
  localparam int PW   = DW + 1 + HB_COEF_W;
  localparam int CPW  = DW + HB_COEF_W;
  localparam int ACCW = PW + $clog2(HB_PAIRS) + 1;
  localparam logic signed [HB_COEF_W-1:0] CC = HB_COEF_W'(HB_CENTRE);

  logic signed [PW-1:0]   prod [HB_PAIRS];
  logic signed [CPW-1:0]  cprod;
  logic signed [ACCW-1:0] accs [2];
  logic signed [OW-1:0]   ys   [2];

  for (genvar g = 0; g < HB_PAIRS; g++) begin : g_pair
    localparam logic signed [HB_COEF_W-1:0] CK = HB_COEF_W'(hb_outer_coef(g));
    logic signed [DW:0] pre;
    assign pre     = (DW+1)'(taps[g]) + (DW+1)'(taps[NT-1-g]);
    assign prod[g] = PW'(pre) * PW'(CK);
  end

  assign cprod = CPW'(taps[HB_PAIRS-1]) * CPW'(CC);

  always_comb begin
    accs[0] = '0;
    for (int i = 0; i < HB_PAIRS; i++) accs[0] = accs[0] + ACCW'(prod[i]);
    accs[1] = ACCW'(cprod);
  end

  for (genvar p = 0; p < 2; p++) begin : g_scale
    hbf_round_sat #(.IW(ACCW), .OW(OW), .SHIFT(SHIFT)) u_rs (
      .acc (accs[p]),
      .y   (ys[p])
    );
  end

  assign outer_y  = ys[0];
  assign centre_y = ys[1];
endmodule

// File: rtl/hbf_out_seq.sv
module hbf_out_seq #(
  parameter int OW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fresh,
  input  logic signed [OW-1:0] even_in,
  input  logic signed [OW-1:0] odd_in,
  input  logic                 out_ready,
  output logic                 load,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data,
  output logic                 out_phase
);
  logic                 busy, ph;
  logic signed [OW-1:0] ev_q, od_q;

  assign load = fresh && (!busy || (ph && out_ready));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ph   <= 1'b0;
      ev_q <= '0;
      od_q <= '0;
    end else if (load) begin
      busy <= 1'b1;
      ph   <= 1'b0;
      ev_q <= even_in;
      od_q <= odd_in;
    end else if (busy && out_ready) begin
      if (ph) busy <= 1'b0;
      else    ph   <= 1'b1;
    end
  end

  assign out_valid = busy;
  assign out_phase = ph;
  assign out_data  = ph ? od_q : ev_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_phase)); // R7
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_phase |=> out_valid && out_phase); // R2
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R1
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_phase && fresh |=> out_valid && !out_phase); // R10
endmodule

// File: rtl/hbf_interp2.sv
module hbf_interp2 import hbf_pkg::*; #(
  parameter int DW          = 16,
  parameter int OW          = 16,
  parameter int SHIFT       = 11,
  parameter bit EXTRA_STAGE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [OW-1:0] out_data,
  output logic                 out_phase
);
  localparam int NT = 2 * HB_PAIRS;

  logic                 s_valid, s_ready, shift, fresh, load;
  logic signed [DW-1:0] s_data;
  logic signed [DW-1:0] taps [NT];
  logic signed [OW-1:0] outer_y, centre_y;

  if (EXTRA_STAGE) begin : g_extra
    logic                 full;
    logic signed [DW-1:0] hold;
    assign in_ready = !full || s_ready;
    always_ff @(posedge clk) begin
      if (rst) begin
        full <= 1'b0;
        hold <= '0;
      end else if (in_ready) begin
        full <= in_valid;
        hold <= in_data;
      end
    end
    assign s_valid = full;
    assign s_data  = hold;
  end else begin : g_direct
    assign s_valid  = in_valid;
    assign s_data   = in_data;
    assign in_ready = s_ready;
  end

  assign s_ready = !fresh || load;
  assign shift   = s_valid && s_ready;

  hbf_tap_line #(.DW(DW), .LEN(NT)) u_line (
    .clk     (clk),
    .rst     (rst),
    .shift   (shift),
    .consume (load),
    .din     (s_data),
    .taps    (taps),
    .fresh   (fresh)
  );

  hbf_phase_mac #(.DW(DW), .OW(OW), .SHIFT(SHIFT)) u_mac (
    .taps     (taps),
    .outer_y  (outer_y),
    .centre_y (centre_y)
  );

  hbf_out_seq #(.OW(OW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .fresh     (fresh),
    .even_in   (outer_y),
    .odd_in    (centre_y),
    .out_ready (out_ready),
    .load      (load),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_phase (out_phase)
  );

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && fresh |-> !s_ready); // R7
endmodule

// File: tb/test_hbf_interp2.sv
module test_hbf_interp2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_valid1 = 1'b0, out_ready = 1'b1;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid, out_phase;
  logic in_ready1, out_valid1, out_phase1;
  logic signed [15:0] out_data, out_data1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbf_interp2 i_hbf_interp2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_phase(out_phase)
  );

  hbf_interp2 #(.EXTRA_STAGE(1'b1)) i_hbf_interp2_q (
    .clk(clk), .rst(rst), .in_valid(in_valid1), .in_ready(in_ready1), .in_data(in_data),
    .out_valid(out_valid1), .out_ready(1'b1), .out_data(out_data1), .out_phase(out_phase1)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";
  int rdy_mode = 0;
  int h43 [43] = '{1,0,-3,0,8,0,-16,0,29,0,-50,0,81,0,-131,0,216,0,-400,0,1264,
                   1998,
                   1264,0,-400,0,216,0,-131,0,81,0,-50,0,29,0,-16,0,8,0,-3,0,1};
  int xh [22];
  int expv [$];
  bit expp [$];
  bit stalled = 0, st_phase = 0;
  int st_data = 0;
  bit sat_hi = 0, sat_lo = 0;

  function automatic int hb_ref(input int ph);
    longint s = 0;
    for (int j = 0; j < 43; j++)
      if ((j % 2) == ph) s += longint'(h43[j]) * xh[(j - ph) / 2];
    s = (s + 1024) >>> 11;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expd);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expd);
    end
  endtask

  // reference model, compared at every negedge (values valid for the next edge)
  always @(negedge clk) begin
    if (rst) begin
      for (int k = 0; k < 22; k++) xh[k] = 0;
      expv.delete(); expp.delete();
      stalled = 0;
    end else begin
      if (stalled)
        check(out_valid && int'(out_data) == st_data && out_phase == st_phase,
              "R7 hold", int'(out_data), st_data);
      if (out_valid && out_ready) begin
        if (expv.size() == 0) check(0, {tag, " unexpected word"}, int'(out_data), 0);
        else begin
          int e; bit p;
          e = expv.pop_front(); p = expp.pop_front();
          check(int'(out_data) == e && out_phase == p, {tag, " data"}, int'(out_data), e);
          if (e == 32767 && !p) sat_hi = 1;
          if (e == -32768 && !p) sat_lo = 1;
        end
      end
      stalled  = out_valid && !out_ready;
      st_data  = int'(out_data);
      st_phase = out_phase;
      if (in_valid && in_ready) begin
        for (int k = 21; k > 0; k--) xh[k] = xh[k-1];
        xh[0] = int'(in_data);
        expv.push_back(hb_ref(0)); expp.push_back(1'b0);
        expv.push_back(hb_ref(1)); expp.push_back(1'b1);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 4) != 0);
  end

  task automatic send(input int v);
    in_valid = 1'b1;
    in_data  = 16'(v);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((expv.size() != 0 || out_valid) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    @(posedge clk); #1;
  endtask

  task automatic impulse_run();
    send(2048);
    for (int k = 0; k < 21; k++) send(0);
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1 out_valid", out_valid, 0);
    check(in_ready, "R1 in_ready", in_ready, 1);
    check(out_data == 0, "R1 out_data", int'(out_data), 0);

    // R8 latency on both variants
    @(posedge clk); #1;
    tag = "R3,R4";
    in_valid = 1'b1; in_valid1 = 1'b1; in_data = 16'sd2048;
    @(posedge clk); #1;
    in_valid = 1'b0; in_valid1 = 1'b0; in_data = '0;
    @(negedge clk);
    check(!out_valid && !out_valid1, "R8 edge k", out_valid, 0);
    @(negedge clk);
    check(out_valid && out_data == 1 && !out_phase, "R8 direct k+1", int'(out_data), 1);
    check(!out_valid1, "R8 extra k+1", out_valid1, 0);
    @(negedge clk);
    check(out_valid1 && out_data1 == 1 && !out_phase1, "R8 extra k+2", int'(out_data1), 1);
    @(posedge clk); #1;
    for (int k = 0; k < 21; k++) send(0);
    drain();

    tag = "R5";
    send(1); send(-1); send(1024); send(-3); send(3);
    for (int k = 0; k < 22; k++) send(0);
    drain();

    tag = "R6";
    for (int i = 21; i >= 0; i--) send(h43[2*i] > 0 ? 32767 : -32768);
    for (int i = 21; i >= 0; i--) send(h43[2*i] > 0 ? -32768 : 32767);
    for (int k = 0; k < 22; k++) send(0);
    drain();
    check(sat_hi, "R6 upper clip seen", sat_hi, 1);
    check(sat_lo, "R6 lower clip seen", sat_lo, 1);

    tag = "R10";
    fork
      for (int k = 0; k < 30; k++) send(int'($urandom % 4096) - 2048);
      begin
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        repeat (40) begin
          check(out_valid, "R10 no bubble", out_valid, 1);
          @(negedge clk);
        end
      end
    join
    drain();

    tag = "R2,R7";
    rdy_mode = 1;
    for (int k = 0; k < 200; k++) begin
      send(int'($urandom % 65536) - 32768);
      repeat ($urandom % 3) @(posedge clk);
      #1;
    end
    drain();

    tag = "R9";
    for (int k = 0; k < 6; k++) send(20000 - k * 7000);
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R9 idle after reset", out_valid, 0);
    check(in_ready, "R9 ready after reset", in_ready, 1);
    rdy_mode = 0;
    @(posedge clk); #1;
    impulse_run();
    check(expv.size() == 0, "R9 model drained", expv.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule